// File: doc/BRIEF.md
# DDR SDRAM Power-Up Command Sequencer

This block brings an external DDR1 or DDR2 SDRAM from reset to normal operation. After reset it samples two straps: one picks the memory generation and the other gives the reference clock frequency. It then walks through a fixed list of steps for that generation. Each step may place a new mode-register value on `mr_value`. One cycle later it pulses exactly one command strobe. It then waits a per-command number of cycles before the next step begins.

In DDR2 mode a configuration word is published before the first command. The DDR2 list also contains a DLL reset, two auto-refreshes, and a pair of extended-mode writes that first load the output-driver calibration defaults and then leave calibration. When the last step's wait has elapsed, the block presents the refresh setting, the default data-strobe tap values and the read-cycle mask. It then raises `init_done` and starts a periodic refresh timer. That timer emits one-cycle refresh requests.

Top module: `ddr_init_seq`

## Requirements
- R1: `cmd_strobe` is one-hot when active and each pulse lasts exactly one cycle. The bit meanings are: bit0 mode-register set, bit1 extended-mode set, bit2 auto-refresh, bit3 precharge-all, bit4 extended-mode-2 set, bit5 extended-mode-3 set.
- R2: With `strap_ddr2`=1 the strobes come in this order, with `mr_value` as shown. The order is: precharge; ext-2 set (0); ext-3 set (0); ext set (0); mode set (0x100); precharge; auto-refresh; auto-refresh; mode set (0xA33); ext set (0x382); ext set (0x402).
- R3: With `strap_ddr2`=0 the order is: precharge; mode set (0x133); ext set (0x002); precharge; mode set (0x033).
- R4: For every mode-register command, `mr_value` holds the step's value from at least one cycle before the strobe through the strobe cycle.
- R5: The next strobe comes exactly D+3 cycles after the previous one. D is T_RP after a precharge, T_RFC after an auto-refresh and T_MRD after any mode-register set.
- R6: `ddr2_cfg` is nonzero only in DDR2 mode, and there it is set before the first strobe. It carries an enable at bit0, tFAW=22 in bits 7:2, on-die termination at bit9 and write latency 2 in bits 13:10 (0xA59). In DDR1 mode it stays 0.
- R7: `init_done` rises exactly D+2 cycles after the last strobe, where D is that strobe's wait. It then stays high, and no strobe follows it.
- R8: `refresh_cfg`, `dqs_tap0`, `dqs_tap1` and `rd_cycle_mask` are 0 until the sequence ends. After it ends they read: refresh enable at bit14 with the interval in bits 9:0 (624 if `strap_ref40`=1, else 390); taps 0x08 and 0x09; mask 0xFF.
- R9: `refresh_req` never rises before `init_done`. It is a one-cycle pulse. The first pulse comes N+1 cycles after `init_done` rises, and later pulses follow every N+1 cycles, where N is the selected interval.
- R10: While `rst_n` is low, every output is 0. A reset at any point, including mid-sequence, restarts the sequence from its first step.
- R11: The straps are sampled once at the start of the sequence. Changing them later has no effect on the order, the values or the refresh interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_ddr2 | input | 1 | 1 selects the DDR2 sequence, 0 selects DDR1 |
| strap_ref40 | input | 1 | 1 means a 40 MHz reference, 0 means 25 MHz |
| cmd_strobe | output | 6 | One-hot command pulse |
| mr_value | output | 13 | Value for the mode register being set |
| ddr2_cfg | output | 14 | DDR2 configuration word |
| refresh_cfg | output | 15 | Refresh enable and interval |
| dqs_tap0 | output | 6 | Data-strobe tap, lane 0 |
| dqs_tap1 | output | 6 | Data-strobe tap, lane 1 |
| rd_cycle_mask | output | 8 | Read-cycle mask |
| init_done | output | 1 | Sequence complete |
| refresh_req | output | 1 | Periodic refresh request pulse |

## Verification
The assertions check the cycle-local rules on every cycle: the strobe is one-hot and one cycle wide, `mr_value` is steady while a strobe is out, `init_done` never drops, no strobe or refresh request breaks the ordering around completion, and the final settings stay frozen. Only the bench scenarios can show the rest. That covers the command order and the mode values for each generation, the exact spacing between strobes, the cycle in which `init_done` rises, the refresh period under both reference straps, and the restart after a reset that lands mid-sequence. The bench also toggles the straps mid-run to confirm they are ignored.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  localparam int CMD_W = 6;
  localparam int MR_W  = 13;
  localparam int IDX_W = 4;

  localparam logic [CMD_W-1:0] CMD_MRS  = 6'b000001;
  localparam logic [CMD_W-1:0] CMD_EMRS = 6'b000010;
  localparam logic [CMD_W-1:0] CMD_REF  = 6'b000100;
  localparam logic [CMD_W-1:0] CMD_PRE  = 6'b001000;
  localparam logic [CMD_W-1:0] CMD_EMR2 = 6'b010000;
  localparam logic [CMD_W-1:0] CMD_EMR3 = 6'b100000;

  // DDR2 configuration word fields
  localparam logic [5:0] D2_TFAW = 6'd22;
  localparam logic [3:0] D2_WL   = 4'd2;
  localparam logic [13:0] D2_CFG_WORD = {D2_WL, 1'b1, 1'b0, D2_TFAW, 1'b0, 1'b1};

  localparam logic [5:0] TAP0_DEF = 6'h08;
  localparam logic [5:0] TAP1_DEF = 6'h09;
  localparam logic [7:0] RD_MASK_DEF = 8'hFF;

  typedef struct packed {
    logic [CMD_W-1:0] cmd;
    logic             has_val;
    logic [MR_W-1:0]  val;
    logic             last;
  } step_t;

  typedef enum logic [2:0] {
    ST_CFG, ST_LOAD, ST_STRB, ST_WAIT, ST_FINAL, ST_DONE
  } seq_st_e;

  function automatic step_t mk_step(input logic [CMD_W-1:0] c, input logic hv,
                                    input logic [MR_W-1:0] v, input logic l);
    step_t s;
    s.cmd = c; s.has_val = hv; s.val = v; s.last = l;
    return s;
  endfunction

  function automatic step_t gen2_step(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0:    return mk_step(CMD_PRE,  1'b0, 13'h000, 1'b0);
      4'd1:    return mk_step(CMD_EMR2, 1'b1, 13'h000, 1'b0);
      4'd2:    return mk_step(CMD_EMR3, 1'b1, 13'h000, 1'b0);
      4'd3:    return mk_step(CMD_EMRS, 1'b1, 13'h000, 1'b0);
      4'd4:    return mk_step(CMD_MRS,  1'b1, 13'h100, 1'b0);
      4'd5:    return mk_step(CMD_PRE,  1'b0, 13'h000, 1'b0);
      4'd6:    return mk_step(CMD_REF,  1'b0, 13'h000, 1'b0);
      4'd7:    return mk_step(CMD_REF,  1'b0, 13'h000, 1'b0);
      4'd8:    return mk_step(CMD_MRS,  1'b1, 13'hA33, 1'b0);
      4'd9:    return mk_step(CMD_EMRS, 1'b1, 13'h382, 1'b0);
      default: return mk_step(CMD_EMRS, 1'b1, 13'h402, 1'b1);
    endcase
  endfunction

  function automatic step_t gen1_step(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0:    return mk_step(CMD_PRE,  1'b0, 13'h000, 1'b0);
      4'd1:    return mk_step(CMD_MRS,  1'b1, 13'h133, 1'b0);
      4'd2:    return mk_step(CMD_EMRS, 1'b1, 13'h002, 1'b0);
      4'd3:    return mk_step(CMD_PRE,  1'b0, 13'h000, 1'b0);
      default: return mk_step(CMD_MRS,  1'b1, 13'h033, 1'b1);
    endcase
  endfunction

endpackage

// File: rtl/ddr_init_step_rom.sv
module ddr_init_step_rom
  import ddr_init_pkg::*;
(
  input  logic             gen2,
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);

  always_comb begin
    if (gen2) step = gen2_step(idx);
    else      step = gen1_step(idx);
  end

endmodule

// File: rtl/ddr_init_wait_ctr.sv
module ddr_init_wait_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr_refresh_timer.sv
module ddr_refresh_timer #(
  parameter int REFI_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [REFI_W-1:0] interval,
  output logic              req
);

  logic [REFI_W-1:0] cnt_q, cnt_d;
  logic              req_d;
  logic              at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    req_d = 1'b0;
    if (!en) begin
      cnt_d = interval;
    end else if (at_zero) begin
      cnt_d = interval;
      req_d = 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req   <= req_d;
    end
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int T_MRD    = 4,
  parameter int T_RP     = 5,
  parameter int T_RFC    = 12,
  parameter int REFI_40M = 624,
  parameter int REFI_25M = 390
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_ddr2,
  input  logic        strap_ref40,
  output logic [5:0]  cmd_strobe,
  output logic [12:0] mr_value,
  output logic [13:0] ddr2_cfg,
  output logic [14:0] refresh_cfg,
  output logic [5:0]  dqs_tap0,
  output logic [5:0]  dqs_tap1,
  output logic [7:0]  rd_cycle_mask,
  output logic        init_done,
  output logic        refresh_req
);

  localparam int MAX_WAIT = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                           : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int WAIT_W = $clog2(MAX_WAIT + 1) + 1;
  localparam int REFI_W = 10;
  localparam logic [WAIT_W-1:0] W_MRD = WAIT_W'(T_MRD);
  localparam logic [WAIT_W-1:0] W_RP  = WAIT_W'(T_RP);
  localparam logic [WAIT_W-1:0] W_RFC = WAIT_W'(T_RFC);
  localparam logic [REFI_W-1:0] I_40  = REFI_W'(REFI_40M);
  localparam logic [REFI_W-1:0] I_25  = REFI_W'(REFI_25M);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  seq_st_e          state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             gen2_q, ref40_q;
  step_t            step;
  logic             wait_expired;
  logic [WAIT_W-1:0] step_wait;
  logic [REFI_W-1:0] refi;

  logic [CMD_W-1:0] cmd_q;
  logic [MR_W-1:0]  mr_q;
  logic [13:0]      d2cfg_q;
  logic [14:0]      refcfg_q;
  logic [5:0]       tap0_q, tap1_q;
  logic [7:0]       mask_q;
  logic             done_q;

  logic cfg_en, load_en, strb_en, wait_en, final_en;

  ddr_init_step_rom u_rom (
    .gen2 (gen2_q),
    .idx  (idx_q),
    .step (step)
  );

  always_comb begin
    case (step.cmd)
      CMD_PRE: step_wait = W_RP;
      CMD_REF: step_wait = W_RFC;
      default: step_wait = W_MRD;
    endcase
  end

  ddr_init_wait_ctr #(.CNT_W(WAIT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (strb_en),
    .load_val (step_wait),
    .expired  (wait_expired)
  );

  assign refi = ref40_q ? I_40 : I_25;

  ddr_refresh_timer #(.REFI_W(REFI_W)) u_refresh (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (done_q),
    .interval (refi),
    .req      (refresh_req)
  );

  // state decode
  assign cfg_en   = (state_q == ST_CFG);
  assign load_en  = (state_q == ST_LOAD);
  assign strb_en  = (state_q == ST_STRB);
  assign wait_en  = (state_q == ST_WAIT);
  assign final_en = (state_q == ST_FINAL);

  // next state
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      ST_CFG: begin
        state_d = ST_LOAD;
        idx_d   = '0;
      end
      ST_LOAD: state_d = ST_STRB;
      ST_STRB: state_d = ST_WAIT;
      ST_WAIT: begin
        if (wait_expired) begin
          if (step.last) begin
            state_d = ST_FINAL;
          end else begin
            state_d = ST_LOAD;
            idx_d   = idx_q + 1'b1;
          end
        end
      end
      ST_FINAL: state_d = ST_DONE;
      default:  state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_CFG;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  // strap capture and DDR2 configuration word
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gen2_q  <= 1'b0;
      ref40_q <= 1'b0;
      d2cfg_q <= '0;
    end else if (cfg_en) begin
      gen2_q  <= strap_ddr2;
      ref40_q <= strap_ref40;
      d2cfg_q <= strap_ddr2 ? D2_CFG_WORD : 14'd0;
    end
  end

  // mode value then command strobe
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mr_q <= '0;
    end else if (load_en && step.has_val) begin
      mr_q <= step.val;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmd_q <= '0;
    end else if (strb_en) begin
      cmd_q <= step.cmd;
    end else if (wait_en) begin
      cmd_q <= '0;
    end
  end

  // final settings
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      refcfg_q <= '0;
      tap0_q   <= '0;
      tap1_q   <= '0;
      mask_q   <= '0;
      done_q   <= 1'b0;
    end else if (final_en) begin
      refcfg_q <= {1'b1, 4'd0, refi};
      tap0_q   <= TAP0_DEF;
      tap1_q   <= TAP1_DEF;
      mask_q   <= RD_MASK_DEF;
      done_q   <= 1'b1;
    end
  end

  assign cmd_strobe    = cmd_q;
  assign mr_value      = mr_q;
  assign ddr2_cfg      = d2cfg_q;
  assign refresh_cfg   = refcfg_q;
  assign dqs_tap0      = tap0_q;
  assign dqs_tap1      = tap1_q;
  assign rd_cycle_mask = mask_q;
  assign init_done     = done_q;

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  cmd_strobe,
  input logic [12:0] mr_value,
  input logic [14:0] refresh_cfg,
  input logic        init_done,
  input logic        refresh_req
);

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_strobe)); // R1

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe != 6'd0) |=> (cmd_strobe == 6'd0)); // R1

  AST_MR_STEADY_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe != 6'd0) |-> $stable(mr_value)); // R4

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R7

  AST_NO_STROBE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd_strobe == 6'd0)); // R7

  AST_NO_REQ_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !refresh_req); // R9

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |=> !refresh_req); // R9

  AST_REFCFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && $past(init_done)) |-> $stable(refresh_cfg)); // R8

endmodule

bind ddr_init_seq ddr_init_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_strobe  (cmd_strobe),
  .mr_value    (mr_value),
  .refresh_cfg (refresh_cfg),
  .init_done   (init_done),
  .refresh_req (refresh_req)
);

// File: tb/ddr_init_seq_bench.sv
module ddr_init_seq_bench;

  localparam int T_MRD = 3;
  localparam int T_RP  = 4;
  localparam int T_RFC = 7;
  localparam int R40   = 624;
  localparam int R25   = 390;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_ddr2 = 1'b0;
  logic        strap_ref40 = 1'b0;
  logic [5:0]  cmd_strobe;
  logic [12:0] mr_value;
  logic [13:0] ddr2_cfg;
  logic [14:0] refresh_cfg;
  logic [5:0]  dqs_tap0, dqs_tap1;
  logic [7:0]  rd_cycle_mask;
  logic        init_done, refresh_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr_init_seq #(.T_MRD(T_MRD), .T_RP(T_RP), .T_RFC(T_RFC),
                 .REFI_40M(R40), .REFI_25M(R25)) u_ddr_init_seq (
    .clk(clk), .rst_n(rst_n), .strap_ddr2(strap_ddr2), .strap_ref40(strap_ref40),
    .cmd_strobe(cmd_strobe), .mr_value(mr_value), .ddr2_cfg(ddr2_cfg),
    .refresh_cfg(refresh_cfg), .dqs_tap0(dqs_tap0), .dqs_tap1(dqs_tap1),
    .rd_cycle_mask(rd_cycle_mask), .init_done(init_done), .refresh_req(refresh_req)
  );

  // event log
  bit          logging = 0;
  int          nlog, nreq, done_cyc;
  logic [5:0]  log_cmd [32];
  logic [12:0] log_val [32];
  logic [12:0] log_pre [32];
  int          log_cyc [32];
  logic [13:0] cfg_at_first;
  int          req_cyc [4];
  bit          wide_strobe, wide_req, strobe_after_done;
  logic [5:0]  prev_cmd;
  logic        prev_req, prev_done;
  logic [12:0] prev_mr;

  always @(negedge clk) begin
    if (logging) begin
      if (cmd_strobe != 0) begin
        if (prev_cmd != 0) wide_strobe = 1;
        if (init_done) strobe_after_done = 1;
        if (nlog < 32) begin
          log_cmd[nlog] = cmd_strobe;
          log_val[nlog] = mr_value;
          log_pre[nlog] = prev_mr;
          log_cyc[nlog] = cyc;
          if (nlog == 0) cfg_at_first = ddr2_cfg;
        end
        nlog++;
      end
      if (refresh_req) begin
        if (prev_req) wide_req = 1;
        if (nreq < 4) req_cyc[nreq] = cyc;
        nreq++;
      end
      if (init_done && !prev_done) done_cyc = cyc;
    end
    prev_cmd  = cmd_strobe;
    prev_req  = refresh_req;
    prev_done = init_done;
    prev_mr   = mr_value;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic void exp_step(input bit d2, input int i,
                                   output logic [5:0] c, output int v, output bit hv);
    hv = 1;
    v  = 0;
    if (d2) begin
      case (i)
        0, 5: begin c = 6'd8; hv = 0; end
        1: c = 6'd16;
        2: c = 6'd32;
        3: c = 6'd2;
        4: begin c = 6'd1; v = 'h100; end
        6, 7: begin c = 6'd4; hv = 0; end
        8: begin c = 6'd1; v = 'hA33; end
        9: begin c = 6'd2; v = 'h382; end
        default: begin c = 6'd2; v = 'h402; end
      endcase
    end else begin
      case (i)
        0, 3: begin c = 6'd8; hv = 0; end
        1: begin c = 6'd1; v = 'h133; end
        2: begin c = 6'd2; v = 'h002; end
        default: begin c = 6'd1; v = 'h033; end
      endcase
    end
  endfunction

  function automatic int wait_of(input logic [5:0] c);
    if (c == 6'd8) return T_RP;
    if (c == 6'd4) return T_RFC;
    return T_MRD;
  endfunction

  task automatic check_reset_zero();
    check(cmd_strobe == 0 && mr_value == 0 && ddr2_cfg == 0 && refresh_cfg == 0 &&
          dqs_tap0 == 0 && dqs_tap1 == 0 && rd_cycle_mask == 0 && !init_done && !refresh_req,
          "R10 outputs zero in reset", {init_done, refresh_req, cmd_strobe} , 0);
  endtask

  task automatic run_cfg(input bit d2, input bit r40, input bit flip);
    int n, refi, waited;
    logic [5:0] c;
    int v;
    bit hv;
    @(negedge clk);
    rst_n = 0;
    strap_ddr2 = d2;
    strap_ref40 = r40;
    repeat (3) @(negedge clk);
    check_reset_zero();
    logging = 0;
    nlog = 0; nreq = 0; done_cyc = -1;
    wide_strobe = 0; wide_req = 0; strobe_after_done = 0;
    cfg_at_first = '1;
    logging = 1;
    rst_n = 1;
    if (flip) begin
      repeat (20) @(negedge clk);
      strap_ddr2 = ~d2;   // R11: late strap change must be ignored
      strap_ref40 = ~r40;
    end
    waited = 0;
    while (!init_done && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    check(init_done, "R7 sequence completes", init_done, 1);
    // R8 settings before done were zero: verified in reset; check final values
    refi = r40 ? R40 : R25;
    repeat (2 * (refi + 1) + 8) @(negedge clk);
    logging = 0;

    n = d2 ? 11 : 5;
    check(nlog == n, d2 ? "R2 strobe count" : "R3 strobe count", nlog, n);
    for (int i = 0; i < n && i < nlog; i++) begin
      exp_step(d2, i, c, v, hv);
      check($countones(log_cmd[i]) == 1, "R1 one-hot strobe", log_cmd[i], c);
      check(log_cmd[i] == c, d2 ? "R2 command order" : "R3 command order", log_cmd[i], c);
      if (hv) begin
        check(log_val[i] == v, d2 ? "R2 mode value" : "R3 mode value", log_val[i], v);
        check(log_pre[i] == v, "R4 value ahead of strobe", log_pre[i], v);
      end
      if (i > 0) begin
        exp_step(d2, i - 1, c, v, hv);
        check(log_cyc[i] - log_cyc[i-1] == wait_of(c) + 3, "R5 strobe spacing",
              log_cyc[i] - log_cyc[i-1], wait_of(c) + 3);
      end
    end
    check(!wide_strobe, "R1 strobe width one cycle", wide_strobe, 0);
    check(cfg_at_first == (d2 ? (1 + (22 << 2) + (1 << 9) + (2 << 10)) : 0),
          "R6 ddr2 config word", cfg_at_first, d2 ? 'hA59 : 0);
    if (nlog == n) begin
      exp_step(d2, n - 1, c, v, hv);
      check(done_cyc == log_cyc[n-1] + wait_of(c) + 2, "R7 done timing",
            done_cyc, log_cyc[n-1] + wait_of(c) + 2);
    end
    check(!strobe_after_done, "R7 no strobe after done", strobe_after_done, 0);
    check(refresh_cfg == ((1 << 14) | refi), "R8 refresh setting", refresh_cfg, (1 << 14) | refi);
    check(dqs_tap0 == 8 && dqs_tap1 == 9, "R8 tap defaults", {dqs_tap0, dqs_tap1}, {6'd8, 6'd9});
    check(rd_cycle_mask == 8'hFF, "R8 read mask", rd_cycle_mask, 'hFF);
    check(nreq >= 2, "R9 refresh requests seen", nreq, 2);
    if (nreq >= 2) begin
      check(req_cyc[0] == done_cyc + refi + 1, "R9 first refresh", req_cyc[0], done_cyc + refi + 1);
      check(req_cyc[1] - req_cyc[0] == refi + 1, "R9 refresh period",
            req_cyc[1] - req_cyc[0], refi + 1);
    end
    check(!wide_req, "R9 request one cycle", wide_req, 0);
  endtask

  initial begin
    fork
      begin
        run_cfg(1, 1, 0);
        run_cfg(0, 0, 0);
        run_cfg(1, 0, 0);
        run_cfg(0, 1, 0);
        // R10: reset lands mid-sequence, next run must start from step 0
        @(negedge clk);
        rst_n = 0; strap_ddr2 = 1;
        repeat (2) @(negedge clk);
        rst_n = 1;
        repeat (40) @(negedge clk);
        check(!init_done, "R10 mid-sequence state", init_done, 0);
        run_cfg(1, 1, 0);
        // R11: straps toggled after sampling
        run_cfg(1, 0, 1);
        run_cfg(0, 1, 1);
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule